// File: doc/BRIEF.md
# D-PHY Lane Start-of-Transmission Detector

This block sits behind the receive comparators and deserializer of one D-PHY data lane. On every cycle of the sampling clock it sees the two single-ended low-power comparator outputs of the lane. When the deserializer has a new high-speed byte, it also sees that byte together with a strobe. The block only accepts a high-speed burst after it has seen a complete entry sequence. That sequence is a stop state, then a request state, then a low plateau that is at least as long as a programmable count. The first high-speed byte must arrive while both lines still read low.

Once a burst is accepted, the block searches the incoming bit stream for the sync byte at all eight bit offsets. It locks onto the offset where the sync byte is found and forwards every later byte realigned to that boundary. The first forwarded byte carries a start-of-packet flag. An entry that is missing, out of order or too short gives a one-cycle error pulse. The same happens when no sync byte turns up within a programmable number of bytes. In all of these cases the high-speed data is dropped until the lane returns to the stop state.

The controller has six named states. IDLE waits for a stop. STOP holds while LP-11 is seen. REQ holds while LP-01 is seen. BRIDGE counts the LP-00 plateau. SYNC searches for the sync byte. BURST forwards aligned bytes. The transitions are:
- IDLE to STOP on LP-11.
- STOP to REQ on LP-01.
- REQ to BRIDGE on LP-00.
- REQ back to STOP on LP-11.
- BRIDGE to SYNC on a high-speed byte that arrives after a long enough plateau.
- SYNC to BURST when the sync byte matches.
- BRIDGE, SYNC and BURST to STOP on LP-11.
- Any rejection goes to IDLE.

Top module: `sot_detect`

## Requirements
- R1: After reset, out_vld, out_sop, sot_error and burst_active are all 0.
- R2: The line state is the pair {lp_dp, lp_dn}: LP-11 = 11, LP-01 = 01, LP-00 = 00, LP-10 = 10. A burst is accepted when the lane shows LP-11, then LP-01, then LP-00, and then an hs_byte_vld arrives while the pair still reads 00. burst_active goes to 1 at the clock edge that samples that byte.
- R3: The plateau length is the number of cycles that sampled 00 before the cycle of the first high-speed byte. It is accepted when it is greater than or equal to min_low. When it is shorter, the block raises sot_error and forwards no data.
- R4: An hs_byte_vld seen in STOP or REQ, meaning the LP-00 plateau is missing, raises sot_error. No data from that burst is forwarded.
- R5: A line state out of order during entry raises sot_error. This covers 00 directly after 11, 10 in STOP or REQ, and 01 or 10 during the plateau.
- R6: High-speed bits arrive LSB first. On each byte the block examines the 16-bit window {hs_byte, previous byte} at offsets 0 to 7 for the value 0xB8. After a match, every later byte is forwarded as window[off+7:off], using the locked offset. The sync byte itself is not forwarded.
- R7: Each forwarded byte appears on out_byte with out_vld one cycle after the edge that samples its input byte. The first forwarded byte of a burst has out_sop = 1 and all later bytes have out_sop = 0.
- R8: sync_limit counts the high-speed bytes of a burst, including the first one. If byte number sync_limit (counting from 1) completes without a match, the block raises sot_error and drops the burst. A match on that byte is still accepted.
- R9: LP-11 during the plateau, the sync search or the burst ends it. burst_active is 0 after that edge, and a new entry sequence from that stop state is accepted.
- R10: sot_error is a pulse of exactly one cycle per rejection. After a rejection, high-speed bytes produce no output until the lane has been back in LP-11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_dp | input | 1 | Sampled positive-line low-power comparator |
| lp_dn | input | 1 | Sampled negative-line low-power comparator |
| hs_byte | input | 8 | Deserialized high-speed byte, first bit in bit 0 |
| hs_byte_vld | input | 1 | Strobe for a new hs_byte |
| min_low | input | LOW_W | Minimum LP-00 plateau in sampling cycles |
| sync_limit | input | SRCH_W | Bytes allowed for finding the sync byte |
| out_byte | output | 8 | Aligned payload byte |
| out_vld | output | 1 | out_byte is valid |
| out_sop | output | 1 | First aligned byte of a burst |
| sot_error | output | 1 | One-cycle pulse on a rejected entry or sync timeout |
| burst_active | output | 1 | Lane is in sync search or in an aligned burst |

## Verification
The bench builds the block with its default widths: an 8-bit plateau counter and a 6-bit sync search counter. At run time it programs min_low to 5, so a plateau of 4 cycles falls just short and a plateau of 5 is just accepted. It switches sync_limit between 3 and 4 around a burst whose sync byte completes in the fourth byte, which covers both sides of the timeout boundary. The sync byte is shifted to offsets 0, 3 and 7 so that the lowest, a middle and the highest offset all decide the realignment.

// File: rtl/sotd_pkg.sv
package sotd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_REQ,
        ST_BRIDGE,
        ST_SYNC,
        ST_BURST
    } sotd_state_e;

    typedef enum logic [1:0] {
        LP_00 = 2'b00,
        LP_01 = 2'b01,
        LP_10 = 2'b10,
        LP_11 = 2'b11
    } lp_code_e;

    localparam logic [7:0] SYNC_WORD = 8'hB8;
    localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/sotd_lowcnt.sv
module sotd_lowcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!count_en) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sotd_aligner.sv
module sotd_aligner
    import sotd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_vld,
    input  logic [2:0]        lock_off,
    output logic              hit_any,
    output logic [2:0]        hit_off,
    output logic [BYTE_W-1:0] aligned
);
    localparam int unsigned N_OFF = BYTE_W;

    logic [BYTE_W-1:0]   prev_q;
    logic [2*BYTE_W-1:0] win;
    logic [N_OFF-1:0]    hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (byte_vld) begin
            prev_q <= byte_in;
        end
    end

    assign win = {byte_in, prev_q};

    for (genvar k = 0; k < N_OFF; k++) begin : g_off
        assign hit[k] = (win[k +: BYTE_W] == SYNC_WORD);
    end

    always_comb begin
        hit_off = '0;
        for (int k = N_OFF - 1; k >= 0; k--) begin
            if (hit[k]) hit_off = 3'(k);
        end
    end

    assign hit_any = |hit;
    assign aligned = win[lock_off +: BYTE_W];
endmodule

// File: rtl/sot_detect.sv
module sot_detect
    import sotd_pkg::*;
#(
    parameter int unsigned LOW_W  = 8,
    parameter int unsigned SRCH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_dp,
    input  logic              lp_dn,
    input  logic [7:0]        hs_byte,
    input  logic              hs_byte_vld,
    input  logic [LOW_W-1:0]  min_low,
    input  logic [SRCH_W-1:0] sync_limit,
    output logic [7:0]        out_byte,
    output logic              out_vld,
    output logic              out_sop,
    output logic              sot_error,
    output logic              burst_active
);
    localparam logic [SRCH_W:0] ONE_EXT = {{SRCH_W{1'b0}}, 1'b1};

    sotd_state_e       state, nxt;
    lp_code_e          lp;
    logic [LOW_W-1:0]  low_cnt;
    logic              low_en;
    logic              hit_any;
    logic [2:0]        hit_off;
    logic [2:0]        lock_off;
    logic [7:0]        aligned;
    logic [SRCH_W-1:0] srch_cnt;
    logic [SRCH_W:0]   srch_next;
    logic              first_pend;
    logic              do_err, do_out, do_lock, do_accept;

    assign lp        = lp_code_e'({lp_dp, lp_dn});
    assign low_en    = (lp == LP_00) && (state == ST_REQ || state == ST_BRIDGE);
    assign srch_next = {1'b0, srch_cnt} + ONE_EXT;

    sotd_lowcnt #(.W(LOW_W)) i_lowcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (low_en),
        .cnt      (low_cnt)
    );

    sotd_aligner i_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (hs_byte),
        .byte_vld (hs_byte_vld),
        .lock_off (lock_off),
        .hit_any  (hit_any),
        .hit_off  (hit_off),
        .aligned  (aligned)
    );

    always_comb begin
        nxt       = state;
        do_err    = 1'b0;
        do_out    = 1'b0;
        do_lock   = 1'b0;
        do_accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (lp == LP_11) nxt = ST_STOP;
            end
            ST_STOP: begin
                if (hs_byte_vld) begin
                    nxt = ST_IDLE; do_err = 1'b1;
                end else if (lp == LP_01) begin
                    nxt = ST_REQ;
                end else if (lp != LP_11) begin
                    nxt = ST_IDLE; do_err = 1'b1;
                end
            end
            ST_REQ: begin
                if (hs_byte_vld) begin
                    nxt = ST_IDLE; do_err = 1'b1;
                end else if (lp == LP_00) begin
                    nxt = ST_BRIDGE;
                end else if (lp == LP_11) begin
                    nxt = ST_STOP;
                end else if (lp == LP_10) begin
                    nxt = ST_IDLE; do_err = 1'b1;
                end
            end
            ST_BRIDGE: begin
                if (lp == LP_11) begin
                    nxt = ST_STOP;
                end else if (lp != LP_00) begin
                    nxt = ST_IDLE; do_err = 1'b1;
                end else if (hs_byte_vld) begin
                    if (low_cnt >= min_low) begin
                        nxt = ST_SYNC; do_accept = 1'b1;
                    end else begin
                        nxt = ST_IDLE; do_err = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (lp == LP_11) begin
                    nxt = ST_STOP;
                end else if (hs_byte_vld) begin
                    if (hit_any) begin
                        nxt = ST_BURST; do_lock = 1'b1;
                    end else if (srch_next >= {1'b0, sync_limit}) begin
                        nxt = ST_IDLE; do_err = 1'b1;
                    end
                end
            end
            ST_BURST: begin
                if (lp == LP_11) nxt = ST_STOP;
                else if (hs_byte_vld) do_out = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte   <= '0;
            out_vld    <= 1'b0;
            out_sop    <= 1'b0;
            sot_error  <= 1'b0;
            lock_off   <= '0;
            first_pend <= 1'b0;
            srch_cnt   <= '0;
        end else begin
            out_vld   <= do_out;
            out_sop   <= do_out && first_pend;
            sot_error <= do_err;
            if (do_out)  out_byte <= aligned;
            if (do_lock) lock_off <= hit_off;
            if (do_lock)     first_pend <= 1'b1;
            else if (do_out) first_pend <= 1'b0;
            if (do_accept)
                srch_cnt <= {{(SRCH_W-1){1'b0}}, 1'b1};
            else if (state == ST_SYNC && hs_byte_vld && !hit_any)
                srch_cnt <= srch_next[SRCH_W-1:0];
        end
    end

    assign burst_active = (state == ST_SYNC) || (state == ST_BURST);
endmodule

// File: rtl/sotd_checker.sv
module sotd_checker (
    input logic clk,
    input logic rst_n,
    input logic lp_dp,
    input logic lp_dn,
    input logic hs_byte_vld,
    input logic out_vld,
    input logic out_sop,
    input logic sot_error,
    input logic burst_active
);
    assert_entry_on_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> ($past(hs_byte_vld) && !$past(lp_dp) && !$past(lp_dn)));

    assert_out_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(burst_active));

    assert_sop_has_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_vld);

    assert_stop_ends_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_dp && lp_dn && burst_active) |=> !burst_active);

    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sot_error |=> !sot_error);

    assert_err_not_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sot_error |-> (!burst_active && !out_vld));
endmodule

bind sot_detect sotd_checker i_sotd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lp_dp        (lp_dp),
    .lp_dn        (lp_dn),
    .hs_byte_vld  (hs_byte_vld),
    .out_vld      (out_vld),
    .out_sop      (out_sop),
    .sot_error    (sot_error),
    .burst_active (burst_active)
);

// File: tb/test_sot_detect.sv
`timescale 1ns/1ps
module test_sot_detect;
    localparam int LOW_W  = 8;
    localparam int SRCH_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lp_dp = 1'b1, lp_dn = 1'b1;
    logic [7:0]        hs_byte = '0;
    logic              hs_byte_vld = 1'b0;
    logic [LOW_W-1:0]  min_low = 8'd5;
    logic [SRCH_W-1:0] sync_limit = 6'd8;
    logic [7:0]        out_byte;
    logic              out_vld, out_sop, sot_error, burst_active;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    logic prev_err = 1'b0;
    logic [8:0] expq[$];
    logic bitv [0:511];
    int nbytes;

    always #10 clk = ~clk;

    sot_detect #(.LOW_W(LOW_W), .SRCH_W(SRCH_W)) i_sot_detect (
        .clk(clk), .rst_n(rst_n), .lp_dp(lp_dp), .lp_dn(lp_dn),
        .hs_byte(hs_byte), .hs_byte_vld(hs_byte_vld),
        .min_low(min_low), .sync_limit(sync_limit),
        .out_byte(out_byte), .out_vld(out_vld), .out_sop(out_sop),
        .sot_error(sot_error), .burst_active(burst_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bytes, counts error pulses
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sot_error) begin
                    err_seen++;
                    if (prev_err) chk(1'b0, "R10 error pulse longer than one cycle", 2, 1);
                end
                prev_err = sot_error;
                if (out_vld) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R10 unexpected output byte", int'(out_byte), 0);
                    end else begin
                        logic [8:0] e;
                        e = expq.pop_front();
                        chk({out_sop, out_byte} == e, "R6/R7 aligned byte and sop",
                            int'({out_sop, out_byte}), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic lp(input logic dp, input logic dn, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lp_dp = dp; lp_dn = dn; hs_byte_vld = 1'b0;
        end
    endtask

    // stream: 16 zero bits, s extra zeros, sync byte, 4 payload bytes; LSB first
    task automatic build(input int s, input int seed);
        logic [7:0] pl;
        for (int i = 0; i < 512; i++) bitv[i] = 1'b0;
        for (int b = 0; b < 8; b++) bitv[16 + s + b] = 8'hB8 >> b;
        for (int j = 0; j < 4; j++) begin
            pl = 8'(seed + j * 37);
            for (int b = 0; b < 8; b++) bitv[24 + s + 8 * j + b] = pl[b];
        end
        nbytes = (24 + s + 32 + 7) / 8;
    endtask

    task automatic push_expected(input int s);
        for (int i = 4; i < nbytes; i++) begin
            logic [7:0] v;
            for (int b = 0; b < 8; b++) v[b] = bitv[8 * (i - 1) + s + b];
            expq.push_back({(i == 4), v});
        end
    endtask

    task automatic send_bytes();
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            lp_dp = 1'b0; lp_dn = 1'b0; hs_byte_vld = 1'b1;
            for (int b = 0; b < 8; b++) hs_byte[b] = bitv[8 * i + b];
        end
        @(negedge clk);
        hs_byte_vld = 1'b0;
    endtask

    task automatic entry(input int nlow);
        lp(1'b1, 1'b1, 3);
        lp(1'b0, 1'b1, 2);
        lp(1'b0, 1'b0, nlow);
    endtask

    task automatic expect_errs(input int base, input int n, input string tag);
        chk(err_seen - base == n, tag, err_seen - base, n);
    endtask

    task automatic good_burst(input int s, input int nlow, input int seed, input string tag);
        int base;
        base = err_seen;
        build(s, seed);
        push_expected(s);
        entry(nlow);
        send_bytes();
        chk(burst_active == 1'b1, {tag, " burst_active during burst"}, burst_active, 1);
        lp(1'b1, 1'b1, 1);
        @(negedge clk);
        chk(burst_active == 1'b0, "R9 LP-11 ends burst", burst_active, 0);
        lp(1'b1, 1'b1, 2);
        chk(expq.size() == 0, {tag, " all bytes delivered"}, expq.size(), 0);
        expect_errs(base, 0, {tag, " no error"});
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk(out_vld == 0 && out_sop == 0 && sot_error == 0 && burst_active == 0,
            "R1 reset outputs", {out_vld, out_sop, sot_error, burst_active}, 0);
        rst_n = 1'b1;
        lp(1'b1, 1'b1, 2);
        chk(burst_active == 0, "R1 idle after reset", burst_active, 0);

        // R2 R3 R6 R7: plateau exactly min_low, offset 3
        good_burst(3, 5, 8'h3C, "R3 boundary accept");

        // R3: plateau one short of min_low, HS data must be dropped
        base = err_seen;
        build(2, 8'h11);
        entry(4);
        send_bytes();
        chk(burst_active == 0, "R3 short plateau rejected", burst_active, 0);
        lp(1'b1, 1'b1, 3);
        expect_errs(base, 1, "R3 short plateau error");

        // R4: straight from LP-11 into HS
        base = err_seen;
        build(1, 8'h22);
        lp(1'b1, 1'b1, 3);
        send_bytes();
        lp(1'b1, 1'b1, 3);
        expect_errs(base, 1, "R4 LP-11 to HS error");

        // R4: LP-01 then HS without LP-00
        base = err_seen;
        lp(1'b0, 1'b1, 2);
        send_bytes();
        lp(1'b1, 1'b1, 3);
        expect_errs(base, 1, "R4 LP-01 to HS error");

        // R5: LP-11 straight to LP-00
        base = err_seen;
        lp(1'b1, 1'b1, 3);
        lp(1'b0, 1'b0, 8);
        send_bytes();
        lp(1'b1, 1'b1, 3);
        expect_errs(base, 1, "R5 skipped LP-01 error");

        // R5: LP-10 during request
        base = err_seen;
        lp(1'b0, 1'b1, 2);
        lp(1'b1, 1'b0, 2);
        lp(1'b1, 1'b1, 3);
        expect_errs(base, 1, "R5 LP-10 error");

        // R9: LP-11 inside plateau aborts silently, a new entry works
        base = err_seen;
        lp(1'b0, 1'b1, 2);
        lp(1'b0, 1'b0, 3);
        lp(1'b1, 1'b1, 2);
        expect_errs(base, 0, "R9 plateau abort no error");
        good_burst(0, 6, 8'hA5, "R9 re-entry accepted");

        // R8: sync completes in byte 4; limit 3 times out
        base = err_seen;
        sync_limit = 6'd3;
        build(0, 8'h5A);
        entry(5);
        send_bytes();
        chk(burst_active == 0, "R8 timeout drops burst", burst_active, 0);
        lp(1'b1, 1'b1, 3);
        expect_errs(base, 1, "R8 timeout error");

        // R8: limit 4 just reaches the sync byte
        sync_limit = 6'd4;
        good_burst(0, 5, 8'h5A, "R8 limit boundary accept");

        // R6: highest offset with a long plateau
        sync_limit = 6'd8;
        good_burst(7, 20, 8'hC3, "R6 offset 7");

        lp(1'b1, 1'b1, 4);
        chk(expq.size() == 0, "R7 queue drained", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule